// File: doc/BRIEF.md
# Reset Qualifier and Emulation-Mode Sequencer

This block sits between the reset pin of a small 8-bit microcontroller and its core. It brings the external reset pin and the strap pins into the oscillator clock domain and counts how long the reset pin stays high. The core sees reset only when the pin has stayed high for two machine cycles. A machine cycle is 6 oscillator periods in the fast mode and 12 in the standard mode, so a reset needs 12 or 24 periods. Shorter pulses are dropped. While the pin is high, the port output stages are held in their reset state at once, without waiting for a clock.

When a qualified reset ends, the block captures the external-access strap and decides whether the chip enters on-circuit emulation. In that mode a test host drives the board. Port 0 stops driving, and the other ports, the address-latch strobe and the program-store strobe lose their strong drivers and keep only a weak pull-up. Emulation is left only through a later qualified reset. The internal reset stays asserted for one extra clock after the release, so the captured strap and the emulation flag are stable before the core starts. All pin inputs are plain levels. There is no streaming data path, so the block has no valid/ready interface.

Top module: `rst_emu_seq`

## Requirements
- R1: With `mode6_pin` high (6-clock mode), set `rst_pin` high starting just after a falling clock edge. Count the rising edges from there. `core_rst` rises after rising edge 14 if the pin was high at edges 1 to 12 or longer. A pin held high for fewer edges never asserts it.
- R2: With `mode6_pin` low (12-clock mode), the same rule uses 24 edges of high pin, and `core_rst` rises after edge 26.
- R3: A pulse on `rst_pin` shorter than the qualifying count leaves `core_rst`, `ea_latched` and `emu_mode` unchanged, and the run count starts again from zero.
- R4: `port_hold` is high whenever `rst_pin` is high or `core_rst` is high. The path from `rst_pin` is combinational and needs no clock edge.
- R5: After a qualified reset, `rst_pin` falls just after a falling edge. `core_rst` stays high through the next three rising edges and goes low after the fourth.
- R6: On the third rising edge after `rst_pin` falls, `ea_latched` takes the level `ea_pin` had. `ea_pin` has no effect at any other time.
- R7: `emu_mode` is set on that same release edge when two conditions hold. First, `ale_pin` was low with `psen_pin` high at some point while the reset was qualified. Second, `ale_pin` was still low at release.
- R8: While `emu_mode` is high, `p0_oe` and `drive_oe` are low and `weak_pull` is high. While it is low, the reverse holds.
- R9: `emu_mode` is cleared only when a reset qualifies. Unqualified pulses leave it set.
- R10: While `por_n` is low, `core_rst` is high and `emu_mode` and `ea_latched` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Active-low power-on reset from the analog detector |
| rst_pin | input | 1 | External reset pin level, active high |
| ale_pin | input | 1 | Level on the address-latch strobe pin |
| psen_pin | input | 1 | Level on the program-store strobe pin |
| ea_pin | input | 1 | External-access strap level |
| mode6_pin | input | 1 | 1 selects 6 clocks per machine cycle, 0 selects 12 |
| core_rst | output | 1 | Synchronous reset to the core |
| ea_latched | output | 1 | External-access strap captured at reset release |
| emu_mode | output | 1 | On-circuit emulation active |
| p0_oe | output | 1 | Port 0 output driver enable |
| drive_oe | output | 1 | Strong driver enable for ports 1 to 3 and both strobes |
| weak_pull | output | 1 | Weak pull-up enable for ports 1 to 3 and both strobes |
| port_hold | output | 1 | Forces ports 1 to 3 into their reset state |

## Verification
The assertions assume that `mode6_pin` does not change while a reset pulse is being counted. If it did, the window used to judge a qualification would change partway through. The bench changes the mode only after several idle cycles with `rst_pin` low. The properties also assume that the strap pins stay stable across the synchronizer latency around the release. The stimulus holds `ale_pin`, `psen_pin` and `ea_pin` constant for the whole of each pulse, including its release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_state_e;

  localparam int PIN_W    = 5;
  localparam int PIN_RST  = 0;
  localparam int PIN_ALE  = 1;
  localparam int PIN_PSEN = 2;
  localparam int PIN_EA   = 3;
  localparam int PIN_MODE = 4;

  function automatic int unsigned qual_periods(input int unsigned mc_len,
                                               input int unsigned mc_count);
    return mc_len * mc_count;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned W       = 5,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rstseq_qual.sv
module rstseq_qual
  import rstseq_pkg::*;
#(
  parameter int unsigned MC_SHORT     = 6,
  parameter int unsigned MC_LONG      = 12,
  parameter int unsigned MC_PER_RESET = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_q,
  input  logic       short_q,
  output seq_state_e state_o,
  output logic       qualify_o,
  output logic       release_o
);

  localparam int unsigned QS = qual_periods(MC_SHORT, MC_PER_RESET);
  localparam int unsigned QL = qual_periods(MC_LONG, MC_PER_RESET);
  localparam int unsigned CW = $clog2(QL + 1);

  seq_state_e    state;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] limit;

  always_comb limit = short_q ? CW'(QS - 1) : CW'(QL - 1);

  assign qualify_o = (state == SEQ_RUN) && rst_q && (run_cnt >= limit);
  assign release_o = (state == SEQ_HOLD) && !rst_q;
  assign state_o   = state;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state   <= SEQ_HOLD;
      run_cnt <= '0;
    end else begin
      unique case (state)
        SEQ_RUN: begin
          if (qualify_o) begin
            state   <= SEQ_HOLD;
            run_cnt <= '0;
          end else if (rst_q) begin
            run_cnt <= run_cnt + 1'b1;
          end else begin
            run_cnt <= '0;
          end
        end
        SEQ_HOLD: if (release_o) state <= SEQ_TAIL;
        SEQ_TAIL: state <= SEQ_RUN;
        default:  state <= SEQ_RUN;
      endcase
    end
  end

endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap (
  input  logic clk,
  input  logic por_n,
  input  logic qualify_i,
  input  logic hold_i,
  input  logic release_i,
  input  logic ale_q,
  input  logic psen_q,
  input  logic ea_q,
  output logic ea_lat_o,
  output logic emu_o
);

  logic cand;
  logic strap_ok;

  assign strap_ok = !ale_q && psen_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ea_lat_o <= 1'b0;
      emu_o    <= 1'b0;
      cand     <= 1'b0;
    end else begin
      if (qualify_i) begin
        emu_o <= 1'b0;
        cand  <= strap_ok;
      end else if (hold_i && !release_i && strap_ok) begin
        cand <= 1'b1;
      end
      if (release_i) begin
        ea_lat_o <= ea_q;
        emu_o    <= cand && !ale_q;
        cand     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rstseq_padctl.sv
module rstseq_padctl (
  input  logic emu_i,
  input  logic rst_pin_i,
  input  logic core_rst_i,
  output logic p0_oe_o,
  output logic drive_oe_o,
  output logic weak_pull_o,
  output logic port_hold_o
);

  always_comb begin
    p0_oe_o     = !emu_i;
    drive_oe_o  = !emu_i;
    weak_pull_o = emu_i;
    port_hold_o = rst_pin_i || core_rst_i;
  end

endmodule

// File: rtl/rst_emu_seq.sv
module rst_emu_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned MC_SHORT     = 6,
  parameter int unsigned MC_LONG      = 12,
  parameter int unsigned MC_PER_RESET = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic ale_pin,
  input  logic psen_pin,
  input  logic ea_pin,
  input  logic mode6_pin,
  output logic core_rst,
  output logic ea_latched,
  output logic emu_mode,
  output logic p0_oe,
  output logic drive_oe,
  output logic weak_pull,
  output logic port_hold
);

  localparam logic [PIN_W-1:0] SYNC_RST = PIN_W'(1) << PIN_RST;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_q;
  logic rst_q, ale_q, psen_q, ea_q, mode_q;
  seq_state_e state;
  logic qualify, release_ev;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_RST]  = rst_pin;
    pins_raw[PIN_ALE]  = ale_pin;
    pins_raw[PIN_PSEN] = psen_pin;
    pins_raw[PIN_EA]   = ea_pin;
    pins_raw[PIN_MODE] = mode6_pin;
  end

  rstseq_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .por_n(por_n), .d(pins_raw), .q(pins_q)
  );

  assign rst_q  = pins_q[PIN_RST];
  assign ale_q  = pins_q[PIN_ALE];
  assign psen_q = pins_q[PIN_PSEN];
  assign ea_q   = pins_q[PIN_EA];
  assign mode_q = pins_q[PIN_MODE];

  rstseq_qual #(
    .MC_SHORT(MC_SHORT), .MC_LONG(MC_LONG), .MC_PER_RESET(MC_PER_RESET)
  ) u_qual (
    .clk(clk), .por_n(por_n), .rst_q(rst_q), .short_q(mode_q),
    .state_o(state), .qualify_o(qualify), .release_o(release_ev)
  );

  assign core_rst = (state != SEQ_RUN);

  rstseq_strap u_strap (
    .clk(clk), .por_n(por_n), .qualify_i(qualify),
    .hold_i(state == SEQ_HOLD), .release_i(release_ev),
    .ale_q(ale_q), .psen_q(psen_q), .ea_q(ea_q),
    .ea_lat_o(ea_latched), .emu_o(emu_mode)
  );

  rstseq_padctl u_pad (
    .emu_i(emu_mode), .rst_pin_i(rst_pin), .core_rst_i(core_rst),
    .p0_oe_o(p0_oe), .drive_oe_o(drive_oe), .weak_pull_o(weak_pull),
    .port_hold_o(port_hold)
  );

endmodule

// File: rtl/rst_emu_seq_chk.sv
module rst_emu_seq_chk #(
  parameter int unsigned MC_SHORT     = 6,
  parameter int unsigned MC_LONG      = 12,
  parameter int unsigned MC_PER_RESET = 2
) (
  input logic clk,
  input logic por_n,
  input logic rst_pin,
  input logic rst_q,
  input logic mode_q,
  input logic ale_q,
  input logic core_rst,
  input logic ea_latched,
  input logic emu_mode,
  input logic p0_oe,
  input logic drive_oe,
  input logic weak_pull,
  input logic port_hold
);

  localparam int unsigned QS = MC_SHORT * MC_PER_RESET;
  localparam int unsigned QL = MC_LONG * MC_PER_RESET;
  localparam int unsigned CW = $clog2(QL + 2);

  logic [CW-1:0] hi_len;
  logic [CW-1:0] need;

  always_comb need = mode_q ? CW'(QS) : CW'(QL);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hi_len <= '0;
    else if (!rst_q) hi_len <= '0;
    else if (hi_len != '1) hi_len <= hi_len + 1'b1;
  end

  // R1 R2 R3
  qual_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> hi_len >= need);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst) |-> !$past(rst_q));

  // R6
  ea_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst |=> $stable(ea_latched));

  // R7
  emu_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(emu_mode) |-> !$past(ale_q) && core_rst);

  // R8
  float_chk: assert property (@(posedge clk) disable iff (!por_n)
    emu_mode |-> !p0_oe && !drive_oe && weak_pull);

  // R9
  emu_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(emu_mode) |-> core_rst);

  // R4
  always_comb begin
    if (por_n && rst_pin) begin
      hold_asy_chk: assert (port_hold);
    end
  end

endmodule

bind rst_emu_seq rst_emu_seq_chk #(
  .MC_SHORT(MC_SHORT), .MC_LONG(MC_LONG), .MC_PER_RESET(MC_PER_RESET)
) u_chk (
  .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .rst_q(rst_q),
  .mode_q(mode_q), .ale_q(ale_q), .core_rst(core_rst),
  .ea_latched(ea_latched), .emu_mode(emu_mode), .p0_oe(p0_oe),
  .drive_oe(drive_oe), .weak_pull(weak_pull), .port_hold(port_hold)
);

// File: tb/rst_emu_seq_test.sv
`timescale 1ns/1ps
module rst_emu_seq_test;

  logic clk = 1'b0;
  logic por_n, rst_pin, ale_pin, psen_pin, ea_pin, mode6_pin;
  logic core_rst, ea_latched, emu_mode, p0_oe, drive_oe, weak_pull, port_hold;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string tag;
    bit    cr;
    bit    ea;
    bit    emu;
    bit    hold;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  rst_emu_seq uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ale_pin(ale_pin),
    .psen_pin(psen_pin), .ea_pin(ea_pin), .mode6_pin(mode6_pin),
    .core_rst(core_rst), .ea_latched(ea_latched), .emu_mode(emu_mode),
    .p0_oe(p0_oe), .drive_oe(drive_oe), .weak_pull(weak_pull),
    .port_hold(port_hold)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // monitor: one expectation per rising edge, checked 1 ns after it
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "core_rst", core_rst, e.cr);
      chk(e.tag, "ea_latched", ea_latched, e.ea);
      chk(e.tag, "emu_mode", emu_mode, e.emu);
      chk({e.tag, "/R8"}, "p0_oe", p0_oe, !e.emu);
      chk({e.tag, "/R8"}, "drive_oe", drive_oe, !e.emu);
      chk({e.tag, "/R8"}, "weak_pull", weak_pull, e.emu);
      chk({e.tag, "/R4"}, "port_hold", port_hold, e.hold);
    end
  end

  // driver: called at a falling edge; pin high for p edges, q is the qualifying count
  task automatic run_pulse(string tag, int p, int q, int total, bit ale, bit psen,
                           bit ea, bit ea_before, bit emu_before, bit emu_entry);
    bit qd;
    qd = (p >= q);
    for (int i = 1; i <= total; i++) begin
      exp_t e;
      rst_pin  = (i <= p);
      ale_pin  = ale;
      psen_pin = psen;
      ea_pin   = ea;
      e.tag  = tag;
      e.cr   = qd && (i >= q + 2) && (i < p + 4);
      e.ea   = (qd && i >= p + 3) ? ea : ea_before;
      if (!qd || i < q + 2) e.emu = emu_before;
      else if (i < p + 3)   e.emu = 1'b0;
      else                  e.emu = emu_entry;
      e.hold = rst_pin || e.cr;
      sb.push_back(e);
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    rst_pin = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_pin = 1'b1; ale_pin = 1'b1; psen_pin = 1'b1;
    ea_pin = 1'b0; mode6_pin = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "core_rst", core_rst, 1'b1);
    chk("R10", "emu_mode", emu_mode, 1'b0);
    chk("R10", "ea_latched", ea_latched, 1'b0);
    chk("R10/R4", "port_hold", port_hold, 1'b1);
    @(negedge clk);
    por_n = 1'b1;
    // power-on release behaves as a qualified reset ending (R5, R6)
    run_pulse("R5", 0, -1, 6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: strap changes after release are ignored
    ea_pin = 1'b0;
    run_pulse("R6", 0, 12, 6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4: asynchronous hold, no clock edge in between
    rst_pin = 1'b1; #1;
    chk("R4", "port_hold", port_hold, 1'b1);
    rst_pin = 1'b0; #1;
    chk("R4", "port_hold", port_hold, 1'b0);
    @(negedge clk);
    // R3: one edge short in 6-clock mode
    run_pulse("R3", 11, 12, 17, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R1 + R7: exact qualifying length with emulation straps
    run_pulse("R1", 12, 12, 18, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    // R9: short pulse does not leave emulation
    run_pulse("R9", 5, 12, 11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    mode6_pin = 1'b0;
    idle(4);
    // R2 + R3: one edge short in 12-clock mode
    run_pulse("R2", 23, 24, 29, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R2 + R9: qualified reset leaves emulation, captures strap
    run_pulse("R2", 24, 24, 30, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    // R7: program strobe low blocks entry
    run_pulse("R7", 30, 24, 36, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R7: entry in 12-clock mode with a longer pulse
    run_pulse("R7", 26, 24, 32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    mode6_pin = 1'b1;
    idle(4);
    // R9 + R1: qualified reset in 6-clock mode exits emulation
    run_pulse("R9", 12, 12, 18, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule